// File: doc/BRIEF.md
# Tracking Speed Memory Counter

This block keeps a set speed as a binary count that an external resistor ladder turns into a memory voltage. The count stays fixed while the block is idle. When the cruise logic sees the driver let go of the accelerate or coast control, it pulses an update request. The block then clears the count to zero and steps it upward. Each step waits for a tick from the slow system oscillator. Counting stops once the external memory-update comparator reports that the ladder output is no longer below the measured speed. One count step is roughly half a mile per hour of set speed.

Each update starts from zero, so the block captures a new speed whether it is higher or lower than the stored one. If the comparator never trips, the count stops at its top value and a sticky overflow flag is set. A clear strobe erases the memory at any time, for example at start-up.

The control state machine has two states. ST_IDLE holds the count. ST_TRACK steps the count on ticks. Five transitions connect them:

- start: ST_IDLE to ST_TRACK on an update request.
- stop-on-match: ST_TRACK to ST_IDLE on a tick while the comparator flag is low.
- stop-on-saturate: ST_TRACK to ST_IDLE on a tick while the flag is high and the count is at its maximum.
- abort: any state to ST_IDLE on clear.
- hold: stay in the current state otherwise.

Top module: `speed_memory_tracker`

## Requirements
- R1: After reset, mem_code is 0, upd_busy is 0 and upd_ovf is 0.
- R2: An upd_req pulse while upd_busy is low (and clr low) gives mem_code = 0, upd_busy = 1 and upd_ovf = 0 on the next cycle.
- R3: While upd_busy is high, each cycle with tick_en = 1, mem_below = 1 and mem_code below 511 raises mem_code by exactly 1 on the next cycle. Without tick_en, mem_code does not change.
- R4: While upd_busy is high, a cycle with tick_en = 1 and mem_below = 0 drops upd_busy on the next cycle and leaves mem_code unchanged. The stored value is therefore the first code at which the comparator stops reporting "below".
- R5: While upd_busy is high, a cycle with tick_en = 1, mem_below = 1 and mem_code = 511 drops upd_busy, sets upd_ovf and keeps mem_code at 511.
- R6: While upd_busy is low, mem_code is stable whatever tick_en and mem_below do, unless clr or upd_req is asserted.
- R7: clr in any state gives mem_code = 0, upd_busy = 0 and upd_ovf = 0 on the next cycle. clr wins over a simultaneous upd_req.
- R8: upd_req while upd_busy is high is ignored: the count is not restarted and tracking continues.
- R9: upd_ovf stays set until the next update starts or clr. It is never high while upd_busy is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle oscillator tick that paces counting |
| upd_req | input | 1 | Update request (control released) |
| mem_below | input | 1 | Comparator flag: ladder output below measured speed |
| clr | input | 1 | Memory erase strobe |
| mem_code | output | 9 | Stored speed code feeding the ladder |
| upd_busy | output | 1 | High while an update is tracking |
| upd_ovf | output | 1 | Sticky flag: last update saturated at the top code |

## Verification
The properties assume that mem_below is a function of the current mem_code that the comparator settles before the next clock edge. They also assume it is monotone, so it stays low once the code reaches the measured speed. The bench meets both assumptions by modelling the comparator as "code below target" on the registered code. It drives a forced constant flag only to reach saturation, or to probe idle behaviour where the flag must have no effect. Targets and tick densities are drawn from a seeded generator and cover values beyond the top code. Every update therefore ends by a match or by saturation.

// File: rtl/speed_memory_pkg.sv
package speed_memory_pkg;

    // Control states of the tracking sequence
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRACK = 2'd1
    } trk_state_e;

    // Operation requested from the count register
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_ZERO = 2'd1,
        CNT_STEP = 2'd2
    } cnt_op_e;

endpackage

// File: rtl/speed_memory_counter.sv
module speed_memory_counter
    import speed_memory_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_op_e          cnt_op,
    output logic [CNT_W-1:0] code,
    output logic             at_max
);

    localparam logic [CNT_W-1:0] CODE_TOP = '1;
    localparam logic [CNT_W-1:0] CODE_ONE = CNT_W'(1);

    logic [CNT_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            unique case (cnt_op)
                CNT_ZERO: code_q <= '0;
                CNT_STEP: if (code_q != CODE_TOP) code_q <= code_q + CODE_ONE;
                default:  code_q <= code_q;
            endcase
        end
    end

    assign code   = code_q;
    assign at_max = (code_q == CODE_TOP);

endmodule

// File: rtl/speed_memory_fsm.sv
module speed_memory_fsm
    import speed_memory_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick_en,
    input  logic    upd_req,
    input  logic    mem_below,
    input  logic    clr,
    input  logic    at_max,
    output cnt_op_e cnt_op,
    output logic    busy,
    output logic    ovf
);

    trk_state_e state_q, state_d;
    logic       ovf_q;
    logic       ovf_set, ovf_clr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Sticky saturation flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (ovf_clr) begin
            ovf_q <= 1'b0;
        end else if (ovf_set) begin
            ovf_q <= 1'b1;
        end
    end

    // Next state and counter commands
    always_comb begin
        state_d = state_q;
        cnt_op  = CNT_HOLD;
        ovf_set = 1'b0;
        ovf_clr = 1'b0;
        if (clr) begin
            // abort
            state_d = ST_IDLE;
            cnt_op  = CNT_ZERO;
            ovf_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (upd_req) begin
                        // start
                        state_d = ST_TRACK;
                        cnt_op  = CNT_ZERO;
                        ovf_clr = 1'b1;
                    end
                end
                ST_TRACK: begin
                    if (tick_en) begin
                        if (!mem_below) begin
                            // stop-on-match
                            state_d = ST_IDLE;
                        end else if (at_max) begin
                            // stop-on-saturate
                            state_d = ST_IDLE;
                            ovf_set = 1'b1;
                        end else begin
                            cnt_op = CNT_STEP;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy = (state_q == ST_TRACK);
        ovf  = ovf_q;
    end

endmodule

// File: rtl/speed_memory_tracker.sv
module speed_memory_tracker
    import speed_memory_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             upd_req,
    input  logic             mem_below,
    input  logic             clr,
    output logic [CNT_W-1:0] mem_code,
    output logic             upd_busy,
    output logic             upd_ovf
);

    cnt_op_e cnt_op;
    logic    at_max;

    speed_memory_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .upd_req   (upd_req),
        .mem_below (mem_below),
        .clr       (clr),
        .at_max    (at_max),
        .cnt_op    (cnt_op),
        .busy      (upd_busy),
        .ovf       (upd_ovf)
    );

    speed_memory_counter #(.CNT_W(CNT_W)) i_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_op (cnt_op),
        .code   (mem_code),
        .at_max (at_max)
    );

endmodule

// File: rtl/speed_memory_tracker_chk.sv
module speed_memory_tracker_chk #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             upd_req,
    input logic             mem_below,
    input logic             clr,
    input logic [CNT_W-1:0] mem_code,
    input logic             upd_busy,
    input logic             upd_ovf
);

    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_busy && upd_req && !clr) |=> (upd_busy && mem_code == '0 && !upd_ovf));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_busy && tick_en && mem_below && mem_code != TOP && !clr)
        |=> (mem_code == $past(mem_code) + ONE));

    p_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_busy && !tick_en && !clr) |=> $stable(mem_code));

    p_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_busy && tick_en && !mem_below && !clr) |=> (!upd_busy && $stable(mem_code)));

    p_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_busy && tick_en && mem_below && mem_code == TOP && !clr)
        |=> (!upd_busy && upd_ovf && mem_code == TOP));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_busy && !upd_req && !clr) |=> $stable(mem_code));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mem_code == '0 && !upd_busy && !upd_ovf));

    p_ovf_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_busy |-> !upd_ovf);

endmodule

bind speed_memory_tracker speed_memory_tracker_chk #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .upd_req   (upd_req),
    .mem_below (mem_below),
    .clr       (clr),
    .mem_code  (mem_code),
    .upd_busy  (upd_busy),
    .upd_ovf   (upd_ovf)
);

// File: tb/test_speed_memory_tracker.sv
module test_speed_memory_tracker;

    localparam int W   = 9;
    localparam int TOP = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         upd_req = 1'b0;
    logic         clr = 1'b0;
    logic         mem_below;
    logic [W-1:0] mem_code;
    logic         upd_busy;
    logic         upd_ovf;

    // comparator model: ladder below target unless overridden
    logic [10:0]  target = '0;
    logic         force_en = 1'b0;
    logic         force_val = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    always_comb mem_below = force_en ? force_val : ({2'b00, mem_code} < target);

    speed_memory_tracker i_speed_memory_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .upd_req   (upd_req),
        .mem_below (mem_below),
        .clr       (clr),
        .mem_code  (mem_code),
        .upd_busy  (upd_busy),
        .upd_ovf   (upd_ovf)
    );

    function automatic int exp_code(input int tgt);
        return (tgt > TOP) ? TOP : tgt;
    endfunction

    function automatic bit exp_ovf(input int tgt);
        return (tgt > TOP);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Start an update and track it to completion
    task automatic run_update(input int tgt, input int density);
        int prev;
        bit step_ok;
        int n;
        target   = 11'(tgt);
        force_en = 1'b0;
        @(negedge clk);
        upd_req = 1'b1;
        tick_en = 1'b0;
        @(negedge clk);
        upd_req = 1'b0;
        check(upd_busy && mem_code == 0 && !upd_ovf, "R2 start", int'(mem_code), 0);
        prev    = int'(mem_code);
        step_ok = 1;
        n       = 0;
        while (upd_busy && n < 20000) begin
            tick_en = (($urandom % density) == 0);
            @(negedge clk);
            if (int'(mem_code) != prev && int'(mem_code) != prev + 1) step_ok = 0;
            prev = int'(mem_code);
            n++;
        end
        tick_en = 1'b0;
        check(step_ok, "R3 single steps", prev, prev);
        check(!upd_busy, "R4 update ends", int'(upd_busy), 0);
        check(int'(mem_code) == exp_code(tgt), "R4/R5 stored code", int'(mem_code), exp_code(tgt));
        check(upd_ovf == exp_ovf(tgt), "R5 overflow flag", int'(upd_ovf), int'(exp_ovf(tgt)));
    endtask

    // Idle with random ticks and comparator, code must hold
    task automatic idle_wiggle(input int cycles, input int exp, input bit ovf_exp);
        bit ok;
        ok       = 1;
        force_en = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            tick_en   = $urandom % 2;
            force_val = $urandom % 2;
            @(negedge clk);
            if (int'(mem_code) != exp || upd_busy || upd_ovf != ovf_exp) ok = 0;
        end
        tick_en  = 1'b0;
        force_en = 1'b0;
        check(ok, "R6 idle hold", int'(mem_code), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check(mem_code == 0 && !upd_busy && !upd_ovf, "R1 reset", int'(mem_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_code == 0 && !upd_busy && !upd_ovf, "R1 after release", int'(mem_code), 0);

        // R3: no ticks -> no movement while busy
        target = 11'd37;
        upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
        repeat (30) @(negedge clk);
        check(upd_busy && mem_code == 0, "R3 no tick no step", int'(mem_code), 0);
        // R7: clear aborts tracking
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check(!upd_busy && mem_code == 0 && !upd_ovf, "R7 clear aborts", int'(upd_busy), 0);

        run_update(0, 1);     // R4 immediate match
        run_update(300, 1);   // R4 rising
        idle_wiggle(60, 300, 1'b0);
        run_update(100, 2);   // R2 falling speed captured
        run_update(511, 1);   // top code by match, no overflow
        run_update(600, 1);   // R5 saturation
        idle_wiggle(30, TOP, 1'b1); // R9 flag sticks while idle
        run_update(5, 1);     // R9 flag cleared by new start

        // R8: request during tracking ignored
        target = 11'd400;
        upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
        tick_en = 1'b1;
        repeat (50) @(negedge clk);
        upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
        check(upd_busy && mem_code == 51, "R8 request ignored", int'(mem_code), 51);
        while (upd_busy) @(negedge clk);
        tick_en = 1'b0;
        check(mem_code == 400, "R8 tracking completes", int'(mem_code), 400);

        // R7: clear beats simultaneous request in idle
        clr = 1'b1;
        upd_req = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        upd_req = 1'b0;
        check(!upd_busy && mem_code == 0, "R7 clear priority", int'(mem_code), 0);
        @(negedge clk);
        check(!upd_busy && mem_code == 0, "R7 stays idle", int'(upd_busy), 0);

        // R9: clear drops overflow
        run_update(700, 1);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check(!upd_ovf && mem_code == 0, "R9 clear drops overflow", int'(upd_ovf), 0);

        // random targets and tick densities
        for (int k = 0; k < 12; k++) begin
            run_update(int'($urandom % 560), 1 + int'($urandom % 4));
            idle_wiggle(10, int'(mem_code), upd_ovf);
        end

        finish_sim();
    end

endmodule